// File: doc/BRIEF.md
# Split-Word Unsigned Multiplier

This block forms the full double-width unsigned product of two operands. Each operand is twice the half width. The product is built only from half-width multipliers, which map directly onto small hardware multiplier slices. Each operand is cut into an upper half and a lower half. Four half-by-half products are formed and registered. They are then aligned by shifting and summed into the final product.

A request is presented by raising `valid_i` together with the operands. The product appears on `prod_o` exactly two clock cycles later, marked by `valid_o`. A new request may be issued on every cycle. When no request completes, the output keeps the last product it delivered. The default half width is 16 bits, which gives 32-bit operands and a 64-bit product.

Top module: `split_mul`

## Requirements
- R1: While `rst_ni` is low, `valid_o` is 0 and `prod_o` is all zeros.
- R2: When `valid_o` is 1, `prod_o` equals the exact unsigned product of the `a_i` and `b_i` values that were accepted with `valid_i` two cycles earlier.
- R3: `valid_o` is 1 exactly two rising clock edges after a cycle in which `valid_i` was 1, and 0 otherwise.
- R4: The all-ones operands 0xFFFFFFFF × 0xFFFFFFFF give 0xFFFFFFFE00000001. This needs the carry out of the two cross products, which together are 33 bits wide, to be kept.
- R5: A zero in either operand gives a zero product, whatever the other operand is.
- R6: Requests issued on consecutive cycles each return their own correct product on consecutive cycles, so the throughput is one product per cycle.
- R7: Bits [31:16] of an operand act as its upper half and are weighted by 2^16. The upper-by-upper product lands at bits [63:32]. For example, 0x00010000 × 0x00010000 = 0x0000000100000000.
- R8: While no request completes, `prod_o` holds its previous value, even when `a_i` and `b_i` change with `valid_i` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operands on `a_i`/`b_i` are a request |
| a_i | input | 32 | First unsigned operand |
| b_i | input | 32 | Second unsigned operand |
| valid_o | output | 1 | `prod_o` carries a new product |
| prod_o | output | 64 | Unsigned product |

## Verification
Zero operands and one-sided zeros show whether any partial product leaks into the result when it should vanish. Operands with only the upper or only the lower half populated separate the four shift weights from one another. All-ones operands drive the cross-term sum to its carry and catch a truncated 32-bit cross sum. Long back-to-back random bursts, random gaps, and idle cycles with changing operands then tell apart a correct pipeline from one with wrong latency, mixed-up stages, or outputs that drift while idle.

// File: rtl/split_mul_pkg.sv
package split_mul_pkg;
  parameter int unsigned HALF_W_DEFAULT = 16;
  parameter int unsigned LATENCY        = 2;
endpackage

// File: rtl/half_mul.sv
module half_mul #(
  parameter int unsigned HALF_W = split_mul_pkg::HALF_W_DEFAULT
) (
  input  logic [HALF_W-1:0]   x_i,
  input  logic [HALF_W-1:0]   y_i,
  output logic [2*HALF_W-1:0] p_o
);
  localparam int unsigned PW = 2 * HALF_W;

  assign p_o = PW'(x_i) * PW'(y_i);
endmodule

// File: rtl/partial_stage.sv
module partial_stage #(
  parameter int unsigned HALF_W = split_mul_pkg::HALF_W_DEFAULT
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                valid_i,
  input  logic [2*HALF_W-1:0] a_i,
  input  logic [2*HALF_W-1:0] b_i,
  output logic                valid_o,
  output logic [2*HALF_W-1:0] pp_ll_o,
  output logic [2*HALF_W-1:0] pp_lh_o,
  output logic [2*HALF_W-1:0] pp_hl_o,
  output logic [2*HALF_W-1:0] pp_hh_o
);
  localparam int unsigned PW = 2 * HALF_W;

  // pp_c[i][j]: half i of a times half j of b (0 = low, 1 = high)
  logic [PW-1:0] pp_c [2][2];
  logic [PW-1:0] pp_q [2][2];

  for (genvar i = 0; i < 2; i++) begin : g_a
    for (genvar j = 0; j < 2; j++) begin : g_b
      half_mul #(.HALF_W(HALF_W)) i_half_mul (
        .x_i (a_i[i*HALF_W +: HALF_W]),
        .y_i (b_i[j*HALF_W +: HALF_W]),
        .p_o (pp_c[i][j])
      );

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)      pp_q[i][j] <= '0;
        else if (valid_i) pp_q[i][j] <= pp_c[i][j];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) valid_o <= 1'b0;
    else         valid_o <= valid_i;
  end

  assign pp_ll_o = pp_q[0][0];
  assign pp_lh_o = pp_q[0][1];
  assign pp_hl_o = pp_q[1][0];
  assign pp_hh_o = pp_q[1][1];
endmodule

// File: rtl/recombine_stage.sv
module recombine_stage #(
  parameter int unsigned HALF_W = split_mul_pkg::HALF_W_DEFAULT
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                valid_i,
  input  logic [2*HALF_W-1:0] pp_ll_i,
  input  logic [2*HALF_W-1:0] pp_lh_i,
  input  logic [2*HALF_W-1:0] pp_hl_i,
  input  logic [2*HALF_W-1:0] pp_hh_i,
  output logic                valid_o,
  output logic [4*HALF_W-1:0] prod_o
);
  localparam int unsigned PW = 2 * HALF_W;
  localparam int unsigned OW = 4 * HALF_W;

  logic [PW:0]   cross_sum;  // one extra bit keeps the carry
  logic [OW-1:0] sum;

  assign cross_sum = {1'b0, pp_lh_i} + {1'b0, pp_hl_i};
  // hh and ll do not overlap, so they are simply concatenated
  assign sum = {pp_hh_i, pp_ll_i} + (OW'(cross_sum) << HALF_W);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      prod_o  <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) prod_o <= sum;
    end
  end
endmodule

// File: rtl/split_mul.sv
module split_mul #(
  parameter int unsigned HALF_W = split_mul_pkg::HALF_W_DEFAULT
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                valid_i,
  input  logic [2*HALF_W-1:0] a_i,
  input  logic [2*HALF_W-1:0] b_i,
  output logic                valid_o,
  output logic [4*HALF_W-1:0] prod_o
);
  localparam int unsigned PW = 2 * HALF_W;

  logic          v_mid;
  logic [PW-1:0] pp_ll, pp_lh, pp_hl, pp_hh;

  partial_stage #(.HALF_W(HALF_W)) i_partial_stage (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (valid_i),
    .a_i     (a_i),
    .b_i     (b_i),
    .valid_o (v_mid),
    .pp_ll_o (pp_ll),
    .pp_lh_o (pp_lh),
    .pp_hl_o (pp_hl),
    .pp_hh_o (pp_hh)
  );

  recombine_stage #(.HALF_W(HALF_W)) i_recombine_stage (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (v_mid),
    .pp_ll_i (pp_ll),
    .pp_lh_i (pp_lh),
    .pp_hl_i (pp_hl),
    .pp_hh_i (pp_hh),
    .valid_o (valid_o),
    .prod_o  (prod_o)
  );
endmodule

// File: rtl/split_mul_sva.sv
module split_mul_sva #(
  parameter int unsigned HALF_W = split_mul_pkg::HALF_W_DEFAULT
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                valid_i,
  input logic [2*HALF_W-1:0] a_i,
  input logic [2*HALF_W-1:0] b_i,
  input logic                valid_o,
  input logic [4*HALF_W-1:0] prod_o
);
  localparam int unsigned OW = 4 * HALF_W;

  logic [1:0] cyc;  // cycles since reset release, saturating
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cyc <= '0;
    else if (cyc != 2'd3) cyc <= cyc + 2'd1;
  end

  assert_reset_R1: assert property (@(posedge clk_i)
    (!rst_ni && $past(!rst_ni)) |-> (!valid_o && prod_o == '0));

  assert_product_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc >= 2'd2 && valid_o) |->
      prod_o == (OW'($past(a_i, 2)) * OW'($past(b_i, 2))));

  assert_latency_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc >= 2'd2) |-> (valid_o == $past(valid_i, 2)));

  assert_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc >= 2'd2 && !$past(valid_i, 2)) |-> $stable(prod_o));
endmodule

bind split_mul split_mul_sva #(.HALF_W(HALF_W)) i_split_mul_sva (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .valid_i (valid_i),
  .a_i     (a_i),
  .b_i     (b_i),
  .valid_o (valid_o),
  .prod_o  (prod_o)
);

// File: tb/test_split_mul.sv
module test_split_mul;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [31:0] a_i = '0, b_i = '0;
  logic        valid_o;
  logic [63:0] prod_o;

  int total = 0, bad = 0;
  bit done = 0;

  // model history: index 0 driven one cycle ago, index 1 two cycles ago
  logic        hv [2];
  logic [31:0] ha [2], hb [2];
  string       ht [2];
  logic [63:0] exp_prod = '0;

  always #5 clk_i = ~clk_i;

  split_mul i_split_mul (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i),
    .a_i(a_i), .b_i(b_i), .valid_o(valid_o), .prod_o(prod_o)
  );

  task automatic check_outputs();
    if (hv[1]) exp_prod = {32'b0, ha[1]} * {32'b0, hb[1]};
    total++;
    if (valid_o !== hv[1]) begin
      bad++;
      $display("FAIL R3 valid_o: actual=%0b expected=%0b", valid_o, hv[1]);
    end
    total++;
    if (prod_o !== exp_prod) begin
      bad++;
      $display("FAIL %s prod_o: actual=%h expected=%h", ht[1], prod_o, exp_prod);
    end
  endtask

  // called at negedge: check outputs, then drive the next inputs
  task automatic step(input logic v, input logic [31:0] a, input logic [31:0] b,
                      input string tag);
    check_outputs();
    hv[1] = hv[0]; ha[1] = ha[0]; hb[1] = hb[0]; ht[1] = ht[0];
    hv[0] = v;     ha[0] = a;     hb[0] = b;     ht[0] = tag;
    valid_i = v; a_i = a; b_i = b;
    @(negedge clk_i);
  endtask

  initial begin
    for (int i = 0; i < 2; i++) begin
      hv[i] = 1'b0; ha[i] = '0; hb[i] = '0; ht[i] = "R8";
    end
    repeat (3) @(negedge clk_i);
    // R1: reset state
    total++;
    if (valid_o !== 1'b0 || prod_o !== 64'h0) begin
      bad++;
      $display("FAIL R1 reset: actual=%0b/%h expected=0/0", valid_o, prod_o);
    end
    rst_ni = 1'b1;
    step(0, '0, '0, "R8");
    // R5: zero operands
    step(1, 32'h0, 32'hDEADBEEF, "R5");
    step(1, 32'h12345678, 32'h0, "R5");
    step(1, 32'h0, 32'h0, "R5");
    // R4: all ones and cross-carry cases
    step(1, 32'hFFFFFFFF, 32'hFFFFFFFF, "R4");
    step(1, 32'hFFFFFFFF, 32'h1, "R4");
    step(1, 32'h0000FFFF, 32'hFFFF0000, "R4");
    // R7: half weights
    step(1, 32'h00010000, 32'h00010000, "R7");
    step(1, 32'h00010000, 32'h00000001, "R7");
    step(1, 32'h00000001, 32'h00010000, "R7");
    step(1, 32'hFFFF0000, 32'hFFFF0000, "R7");
    step(1, 32'h0000FFFF, 32'h0000FFFF, "R7");
    // R8: idle cycles with changing operands keep the last product
    for (int i = 0; i < 6; i++) step(0, $urandom, $urandom, "R8");
    step(1, 32'h00000007, 32'h00000009, "R2");
    for (int i = 0; i < 5; i++) step(0, $urandom, $urandom, "R8");
    // R6: back-to-back burst
    for (int i = 0; i < 300; i++) step(1, $urandom, $urandom, "R6");
    // R2: random with gaps
    for (int i = 0; i < 400; i++) begin
      if ($urandom_range(0, 2) == 0) step(0, $urandom, $urandom, "R8");
      else                           step(1, $urandom, $urandom, "R2");
    end
    for (int i = 0; i < 3; i++) step(0, '0, '0, "R8");
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule